// File: doc/BRIEF.md
# Remappable Pin Crossbar

This block routes signals between a set of remappable device pins and the on-chip peripherals under register control. Each peripheral input owns a select register holding the number of the pin it listens to. Each remappable pin owns a select register holding a function code naming the peripheral output that drives it. Code zero leaves the pin to the ordinary port logic. Routing is purely combinational from the registered selects, so a changed mapping takes effect on the cycle after the write.

A lock bit protects the whole mapping. While it is set, writes to every select register are dropped. The lock itself moves only after a two-write key sequence to a key register, and the lock write must be the very next bus access. The crossbar never touches pad direction: it hands the pad logic the routed value, the routed enable and a flag saying a peripheral owns the pin.

Bus map (byte data): lock register at 0x00 (bit 0), key register at 0x01, input selects at 0x40 + k, output selects at 0x80 + j. Select fields are 6 bits wide and read back with bits 7:6 as zero.

Top module: `pin_route_xbar`

## Requirements
- R1: After reset every output select reads 0, every input select reads 0x3F, the lock reads 0, and no pin is owned or driven.
- R2: An input select holding a value p below NUM_PINS makes func_in[k] follow pin_in[p] combinationally.
- R3: An input select holding a value at or above NUM_PINS makes func_in[k] a constant 1, whatever the pins do.
- R4: An output select holding code c in 1..NUM_OUT_FUNCS makes pin_out[j] = periph_out[c-1], pin_oe[j] = periph_oe[c-1] and pin_owned[j] = 1; codes 1 to 4 are, in order, comparator 1 output, comparator 2 output, UART1 transmit and UART1 RTS.
- R5: Output code 0, or any code above NUM_OUT_FUNCS, leaves pin_owned, pin_oe and pin_out at 0 for that pin.
- R6: Every select register reads back its 6-bit field at its address, with bits 7:6 read as 0; the lock register reads the lock in bit 0.
- R7: While the lock is 1, writes to any select register change neither its read-back value nor the routing.
- R8: A write to the lock register changes the lock to wdata bit 0 only when it is the next bus access after a write of 0x46 and then a write of 0x57 to the key register; idle cycles between accesses do not count as accesses.
- R9: Any other bus access (a read, a write elsewhere, or a wrong key value) in the sequence cancels it, and a lock write without a completed sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | NUM_PINS | Values sampled from the remappable pins |
| func_in | output | NUM_IN_FUNCS | Routed pin values into peripheral inputs |
| periph_out | input | NUM_OUT_FUNCS | Peripheral output values, bit c-1 belongs to code c |
| periph_oe | input | NUM_OUT_FUNCS | Peripheral output enables, bit c-1 belongs to code c |
| pin_out | output | NUM_PINS | Routed output value per pin |
| pin_oe | output | NUM_PINS | Routed output enable per pin |
| pin_owned | output | NUM_PINS | A peripheral output is selected for the pin |

## Verification
The bench builds the crossbar with 12 pins, 4 peripheral inputs and 6 output functions. With a pin count that small, pin numbers between 12 and 63 are writable and exercise the constant-one fallback, and the last legal code 6 sits right beside the first illegal code 7. The same small sizes make it quick to walk the key sequence through its aborting cases and confirm that locked writes leave both read-back and routing untouched.

// File: rtl/pin_route_xbar.sv
module pin_route_xbar #(
  parameter int NUM_PINS      = 16,
  parameter int NUM_IN_FUNCS  = 8,
  parameter int NUM_OUT_FUNCS = 8,
  parameter bit LOCK_INIT     = 1'b0,
  parameter logic [7:0] KEY_A = 8'h46,
  parameter logic [7:0] KEY_B = 8'h57
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_IN_FUNCS-1:0]  func_in,
  input  logic [NUM_OUT_FUNCS-1:0] periph_out,
  input  logic [NUM_OUT_FUNCS-1:0] periph_oe,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_PINS-1:0]      pin_oe,
  output logic [NUM_PINS-1:0]      pin_owned
);

  localparam int FW = 6;
  localparam logic [7:0] LOCK_ADDR = 8'h00;
  localparam logic [7:0] KEY_ADDR  = 8'h01;
  localparam int IN_BASE  = 'h40;
  localparam int OUT_BASE = 'h80;
  localparam logic [FW-1:0] IN_RST = {FW{1'b1}};

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_t;

  logic [NUM_IN_FUNCS-1:0][FW-1:0] in_sel_q;
  logic [NUM_PINS-1:0][FW-1:0]     out_sel_q;
  logic                            lock_q;
  key_t                            key_q;
  logic                            access;

  assign access = bus_wr | bus_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= K_IDLE;
      lock_q <= LOCK_INIT;
    end else if (access) begin
      if (bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_A)
        key_q <= K_HALF;
      else if (key_q == K_HALF && bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_B)
        key_q <= K_ARMED;
      else
        key_q <= K_IDLE;
      if (key_q == K_ARMED && bus_wr && bus_addr == LOCK_ADDR)
        lock_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_IN_FUNCS; k++) in_sel_q[k] <= IN_RST;
      for (int j = 0; j < NUM_PINS; j++) out_sel_q[j] <= '0;
    end else if (bus_wr && !lock_q) begin
      for (int k = 0; k < NUM_IN_FUNCS; k++)
        if (bus_addr == 8'(IN_BASE + k)) in_sel_q[k] <= bus_wdata[FW-1:0];
      for (int j = 0; j < NUM_PINS; j++)
        if (bus_addr == 8'(OUT_BASE + j)) out_sel_q[j] <= bus_wdata[FW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == LOCK_ADDR) bus_rdata = {7'd0, lock_q};
    for (int k = 0; k < NUM_IN_FUNCS; k++)
      if (bus_addr == 8'(IN_BASE + k)) bus_rdata = {2'b00, in_sel_q[k]};
    for (int j = 0; j < NUM_PINS; j++)
      if (bus_addr == 8'(OUT_BASE + j)) bus_rdata = {2'b00, out_sel_q[j]};
  end

  always_comb begin
    for (int k = 0; k < NUM_IN_FUNCS; k++) begin
      func_in[k] = 1'b1;
      for (int p = 0; p < NUM_PINS; p++)
        if (in_sel_q[k] == FW'(p)) func_in[k] = pin_in[p];
    end
  end

  always_comb begin
    for (int j = 0; j < NUM_PINS; j++) begin
      pin_out[j]   = 1'b0;
      pin_oe[j]    = 1'b0;
      pin_owned[j] = 1'b0;
      for (int c = 1; c <= NUM_OUT_FUNCS; c++)
        if (out_sel_q[j] == FW'(c)) begin
          pin_out[j]   = periph_out[c-1];
          pin_oe[j]    = periph_oe[c-1];
          pin_owned[j] = 1'b1;
        end
    end
  end

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(in_sel_q) && $stable(out_sel_q)));  // R7

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q != K_ARMED) |=> $stable(lock_q));  // R8

  AST_KEY_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> (key_q == K_IDLE));  // R9

  for (genvar k = 0; k < NUM_IN_FUNCS; k++) begin : g_in_chk
    AST_UNMAPPED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel_q[k] >= FW'(NUM_PINS)) |-> func_in[k]);  // R3
  end

  for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin_chk
    AST_NULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel_q[j] == '0) |-> (!pin_owned[j] && !pin_oe[j] && !pin_out[j]));  // R5
  end

endmodule

// File: tb/pin_route_xbar_test.sv
module pin_route_xbar_test;
  localparam int NP = 12, NI = 4, NO = 6;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [NP-1:0] pin_in = 0;
  logic [NI-1:0] func_in;
  logic [NO-1:0] periph_out = 0, periph_oe = 0;
  logic [NP-1:0] pin_out, pin_oe, pin_owned;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pin_route_xbar #(.NUM_PINS(NP), .NUM_IN_FUNCS(NI), .NUM_OUT_FUNCS(NO)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .func_in(func_in), .periph_out(periph_out),
    .periph_oe(periph_oe), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_owned(pin_owned));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic unlock_seq(logic v);
    wr(8'h01, 8'h46); wr(8'h01, 8'h57); wr(8'h00, {7'd0, v});
  endtask

  task automatic t_reset;
    for (int k = 0; k < NI; k++) rd_check("R1 in sel", 8'(8'h40 + k), 8'h3F);
    for (int j = 0; j < NP; j++) rd_check("R1 out sel", 8'(8'h80 + j), 8'h00);
    rd_check("R1 lock", 8'h00, 8'h00);
    periph_out = '1; periph_oe = '1; #1;
    check("R1 owned", pin_owned, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 func_in", func_in, 4'hF);
  endtask

  task automatic t_input;
    wr(8'h40, 8'd3); wr(8'h43, 8'd11);
    pin_in = 12'h008; #1;
    check("R2 func0 high", func_in[0], 1);
    check("R2 func3 low", func_in[3], 0);
    pin_in = 12'h800; #1;
    check("R2 func0 low", func_in[0], 0);
    check("R2 func3 top pin", func_in[3], 1);
    wr(8'h41, 8'd12); pin_in = 0; #1;
    check("R3 sel=12", func_in[1], 1);
    wr(8'h41, 8'd40); #1;
    check("R3 sel=40", func_in[1], 1);
  endtask

  task automatic t_output;
    periph_out = 6'b000001; periph_oe = 6'b000000;
    wr(8'h82, 8'd1); #1;
    check("R4 code1 owned", pin_owned[2], 1);
    check("R4 code1 val", pin_out[2], 1);
    check("R4 code1 oe", pin_oe[2], 0);
    periph_out = 6'b111110; periph_oe = 6'b000001; #1;
    check("R4 code1 val low", pin_out[2], 0);
    check("R4 code1 oe", pin_oe[2], 1);
    wr(8'h8B, 8'd6); periph_out = 6'b100000; periph_oe = 6'b100000; #1;
    check("R4 code6 val", pin_out[11], 1);
    check("R4 code6 oe", pin_oe[11], 1);
    wr(8'h8B, 8'd7); periph_out = '1; periph_oe = '1; #1;
    check("R5 code7 owned", pin_owned[11], 0);
    check("R5 code7 val", {pin_out[11], pin_oe[11]}, 0);
    wr(8'h82, 8'd0); #1;
    check("R5 code0", {pin_owned[2], pin_out[2], pin_oe[2]}, 0);
    check("R5 other pins idle", pin_owned, 0);
  endtask

  task automatic t_readback;
    wr(8'h42, 8'hFF); rd_check("R6 in mask", 8'h42, 8'h3F);
    wr(8'h85, 8'hC4); rd_check("R6 out mask", 8'h85, 8'h04);
  endtask

  task automatic t_lock;
    wr(8'h00, 8'h01); rd_check("R9 lock w/o key", 8'h00, 8'h00);
    unlock_seq(1); rd_check("R8 locked", 8'h00, 8'h01);
    wr(8'h85, 8'd2); rd_check("R7 out frozen", 8'h85, 8'h04);
    wr(8'h40, 8'd5); rd_check("R7 in frozen", 8'h40, 8'h03);
    periph_out = 6'b000010; pin_in = 12'h008; #1;
    check("R7 routing out", pin_out[5], 0);
    check("R7 routing in", func_in[0], 1);
    wr(8'h01, 8'h46); rd_check("R6 key read", 8'h01, 8'h00);
    wr(8'h01, 8'h57); wr(8'h00, 8'h00);
    rd_check("R9 read aborts", 8'h00, 8'h01);
    wr(8'h01, 8'h46); wr(8'h01, 8'h58); wr(8'h00, 8'h00);
    rd_check("R9 bad key", 8'h00, 8'h01);
    wr(8'h01, 8'h46); wr(8'h90, 8'h00); wr(8'h01, 8'h57); wr(8'h00, 8'h00);
    rd_check("R9 other write", 8'h00, 8'h01);
    wr(8'h01, 8'h46); wr(8'h01, 8'h57);
    repeat (3) @(negedge clk);
    wr(8'h00, 8'h00);
    rd_check("R8 idle ok", 8'h00, 8'h00);
    wr(8'h85, 8'd2); rd_check("R7 writable again", 8'h85, 8'h02);
    #1 check("R4 code2 route", pin_out[5], 1);
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_input;
    t_output;
    t_readback;
    t_lock;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule